// File: doc/BRIEF.md
# Transmit Buffer Descriptor Engine

The engine walks a ring of transmit descriptors held in a descriptor RAM outside the block. Each descriptor is two words: a control/length word and a buffer pointer. When the engine finds a descriptor marked ready, it does three things. First, it pulls the frame out of system memory, one 32-bit word at a time, into a local byte buffer. Second, it streams the bytes to the line side. Third, it waits for the line side to report completion, writes the updated control word back and raises interrupt-source pulses.

The engine also produces the frame limits and the CRC decision used by the line logic. The minimum length, the maximum length and the append-CRC flag each combine per-descriptor bits with global mode inputs. These values are registered when a descriptor is accepted and are held until the next one is accepted.

The state machine has four states:
- `ST_IDLE` goes to `ST_WAIT_BD` when transmit is enabled.
- `ST_WAIT_BD` does one of three things:
  - goes to `ST_FETCH` on a ready descriptor;
  - goes back to `ST_IDLE` if enable drops;
  - otherwise stays put.
- `ST_FETCH` goes to `ST_TRANSMIT` once every word covering the frame length has returned.
- `ST_TRANSMIT` goes to `ST_IDLE` on the line-side done pulse.

Top module: `txbd_engine`

## Requirements
- R1: After reset the state is idle and the ring index is 0, so `bd_raddr` is 0. `mem_req_valid`, `tx_valid`, `bd_we`, `int_done_set`, `int_err_set` and `irq` are all low.
- R2: Leaving idle requires `ctl_tx_en`. The engine spins in the descriptor-wait state while enable is high and the ready bit is clear. If enable drops before a ready descriptor appears, the engine goes back to idle and issues no memory read.
- R3: Descriptor layout. Control word bits 31:16 are the length in bytes (1 to BUF_BYTES). Bit 15 is ready, bit 14 is interrupt-request, bit 13 is wrap, bit 12 is pad, bit 11 is CRC and bit 10 is last. Bits 9:1 are transmit status (bit 9 underrun, bit 8 retransmit, bits 7:4 retry count, bit 3 defer, bit 2 collision, bit 1 no-carrier). The second word is the buffer byte address.
- R4: Frame data is read as ceil(length/4) words at buffer address + 0, 4, 8 and so on. At most one read is outstanding. The address and valid are held until `mem_req_ready` is seen.
- R5: Exactly `length` bytes are streamed. Bits 31:24 of each fetched word go out first and bits 7:0 last. `tx_last` marks only the final byte.
- R6: `frame_min_len` is `ctl_min_len` when the descriptor pad bit or `ctl_pad` is set; otherwise it is the descriptor length.
- R7: `frame_max_len` is the descriptor length when `ctl_huge` is set; otherwise it is `ctl_max_len`.
- R8: `frame_add_crc` is 1 when `ctl_crc_en` is set, or when the descriptor has both its CRC bit and its last bit set.
- R9: In the cycle of the done pulse, `bd_we` writes the control word back to the descriptor's own index. The written word is the accepted word with ready cleared and bits 9:1 cleared; all other bits are unchanged.
- R10: In that cycle `int_done_set` pulses when `line_err` is low, and `int_err_set` pulses when it is high.
- R11: `irq` pulses with the write-back only if the descriptor interrupt-request bit is set and the mask for the outcome is set: `mask_done` on success, `mask_err` on error.
- R12: After the write-back, the index returns to 0 if the wrap bit is set or the descriptor was the last entry of the table (word index 2*NUM_BD-2). Otherwise the index advances by 2.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_tx_en | input | 1 | Global transmit enable |
| ctl_pad | input | 1 | Global pad mode |
| ctl_huge | input | 1 | Huge-frame mode |
| ctl_crc_en | input | 1 | Global CRC append |
| ctl_min_len | input | LEN_W | Global minimum frame length |
| ctl_max_len | input | LEN_W | Global maximum frame length |
| mask_done | input | 1 | Interrupt mask for success |
| mask_err | input | 1 | Interrupt mask for error |
| bd_raddr | output | IDX_W | Ring index (word address of control word) |
| bd_rdata0 | input | 32 | Descriptor word at bd_raddr |
| bd_rdata1 | input | 32 | Descriptor word at bd_raddr+1 |
| bd_we | output | 1 | Write-back strobe |
| bd_waddr | output | IDX_W | Write-back word address |
| bd_wdata | output | 32 | Write-back control word |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| tx_valid | output | 1 | Byte stream valid |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Line side accepts byte |
| line_done | input | 1 | One-cycle transmission complete |
| line_err | input | 1 | Completion was an error |
| frame_min_len | output | LEN_W | Minimum length for current frame |
| frame_max_len | output | LEN_W | Maximum length for current frame |
| frame_add_crc | output | 1 | Append CRC to current frame |
| int_done_set | output | 1 | Success interrupt-source pulse |
| int_err_set | output | 1 | Error interrupt-source pulse |
| irq | output | 1 | Interrupt request pulse |

## Verification
A corrupted ring index shows up one cycle after the write-back: `bd_raddr` has the wrong value, and a later write-back lands in the wrong slot. A stale offset or a lost pending flag shows up on the next memory request, either as a wrong address or as a wrong count of reads for the frame. A wrong buffer slot or byte lane appears as a byte mismatch on the stream as soon as that byte is accepted. A latched policy bit that is wrong stays visible on the frame-limit outputs for the whole frame.

// File: rtl/txbd_pkg.sv
package txbd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_BD  = 2'd1,
        ST_FETCH    = 2'd2,
        ST_TRANSMIT = 2'd3
    } txbd_state_e;

    localparam int unsigned B_RDY  = 15;
    localparam int unsigned B_IRQ  = 14;
    localparam int unsigned B_WRAP = 13;
    localparam int unsigned B_PAD  = 12;
    localparam int unsigned B_CRC  = 11;
    localparam int unsigned B_LAST = 10;

    // Status bits cleared when a descriptor is taken (9:1)
    localparam logic [31:0] STATUS_CLR = 32'h0000_03FE;

endpackage

// File: rtl/txbd_policy.sv
module txbd_policy #(
    parameter int unsigned LEN_W = 16
) (
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_pad,
    input  logic             desc_crc,
    input  logic             desc_last,
    input  logic             g_pad,
    input  logic             g_huge,
    input  logic             g_crc,
    input  logic [LEN_W-1:0] g_min,
    input  logic [LEN_W-1:0] g_max,
    output logic [LEN_W-1:0] min_len,
    output logic [LEN_W-1:0] max_len,
    output logic             add_crc
);
    always_comb begin
        min_len = (desc_pad || g_pad) ? g_min : desc_len;
        max_len = g_huge ? desc_len : g_max;
        add_crc = g_crc || (desc_crc && desc_last);
    end
endmodule

// File: rtl/txbd_byte_buf.sv
module txbd_byte_buf #(
    parameter int unsigned BUF_BYTES = 64
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [$clog2(BUF_BYTES)-3:0] wr_widx,
    input  logic [31:0]                  wr_data,
    input  logic [$clog2(BUF_BYTES)-1:0] rd_bidx,
    output logic [7:0]                   rd_byte
);
    localparam int unsigned WORDS = BUF_BYTES / 4;
    localparam int unsigned WI_W  = $clog2(BUF_BYTES) - 2;

    logic [31:0] word_arr [WORDS];
    logic [31:0] sel_word;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [31:0] w_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_widx == WI_W'(w)) begin
                w_q <= wr_data;
            end
        end
        assign word_arr[w] = w_q;
    end

    always_comb begin
        sel_word = word_arr[rd_bidx[WI_W+1:2]];
        unique case (rd_bidx[1:0])
            2'd0: rd_byte = sel_word[31:24];
            2'd1: rd_byte = sel_word[23:16];
            2'd2: rd_byte = sel_word[15:8];
            default: rd_byte = sel_word[7:0];
        endcase
    end
endmodule

// File: rtl/txbd_ring_index.sv
module txbd_ring_index #(
    parameter int unsigned NUM_BD = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv,
    input  logic                          wrap,
    output logic [$clog2(2*NUM_BD)-1:0]   idx
);
    localparam int unsigned IDX_W     = $clog2(2*NUM_BD);
    localparam int unsigned LAST_WORD = 2*NUM_BD - 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (adv) begin
            if (wrap || idx == IDX_W'(LAST_WORD)) begin
                idx <= '0;
            end else begin
                idx <= idx + IDX_W'(2);
            end
        end
    end

    AST_IDX_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !idx[0]); // R12
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx)); // R12
endmodule

// File: rtl/txbd_engine.sv
module txbd_engine
    import txbd_pkg::*;
#(
    parameter int unsigned NUM_BD    = 8,
    parameter int unsigned BUF_BYTES = 64,
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned ADDR_W    = 32,
    localparam int unsigned IDX_W    = $clog2(2*NUM_BD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_tx_en,
    input  logic              ctl_pad,
    input  logic              ctl_huge,
    input  logic              ctl_crc_en,
    input  logic [LEN_W-1:0]  ctl_min_len,
    input  logic [LEN_W-1:0]  ctl_max_len,
    input  logic              mask_done,
    input  logic              mask_err,
    output logic [IDX_W-1:0]  bd_raddr,
    input  logic [31:0]       bd_rdata0,
    input  logic [31:0]       bd_rdata1,
    output logic              bd_we,
    output logic [IDX_W-1:0]  bd_waddr,
    output logic [31:0]       bd_wdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              line_done,
    input  logic              line_err,
    output logic [LEN_W-1:0]  frame_min_len,
    output logic [LEN_W-1:0]  frame_max_len,
    output logic              frame_add_crc,
    output logic              int_done_set,
    output logic              int_err_set,
    output logic              irq
);
    localparam int unsigned BYTE_AW = $clog2(BUF_BYTES);

    txbd_state_e        state_q;
    logic [31:0]        desc_q;
    logic [ADDR_W-1:0]  baddr_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   off_q;
    logic [LEN_W-1:0]   ptr_q;
    logic               pend_q;
    logic               sent_all_q;

    logic [LEN_W-1:0]   pol_min;
    logic [LEN_W-1:0]   pol_max;
    logic               pol_crc;
    logic               buf_we;
    logic [7:0]         buf_byte;
    logic               finish;
    logic [IDX_W-1:0]   idx;

    txbd_policy #(.LEN_W(LEN_W)) u_policy (
        .desc_len  (bd_rdata0[31:16]),
        .desc_pad  (bd_rdata0[B_PAD]),
        .desc_crc  (bd_rdata0[B_CRC]),
        .desc_last (bd_rdata0[B_LAST]),
        .g_pad     (ctl_pad),
        .g_huge    (ctl_huge),
        .g_crc     (ctl_crc_en),
        .g_min     (ctl_min_len),
        .g_max     (ctl_max_len),
        .min_len   (pol_min),
        .max_len   (pol_max),
        .add_crc   (pol_crc)
    );

    txbd_byte_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_widx (off_q[BYTE_AW-1:2]),
        .wr_data (mem_rsp_data),
        .rd_bidx (ptr_q[BYTE_AW-1:0]),
        .rd_byte (buf_byte)
    );

    txbd_ring_index #(.NUM_BD(NUM_BD)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (finish),
        .wrap  (desc_q[B_WRAP]),
        .idx   (idx)
    );

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            desc_q        <= '0;
            baddr_q       <= '0;
            len_q         <= '0;
            off_q         <= '0;
            ptr_q         <= '0;
            pend_q        <= 1'b0;
            sent_all_q    <= 1'b0;
            frame_min_len <= '0;
            frame_max_len <= '0;
            frame_add_crc <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ctl_tx_en) state_q <= ST_WAIT_BD;
                end
                ST_WAIT_BD: begin
                    if (bd_rdata0[B_RDY]) begin
                        desc_q        <= bd_rdata0 & ~STATUS_CLR;
                        baddr_q       <= bd_rdata1[ADDR_W-1:0];
                        len_q         <= bd_rdata0[31:16];
                        off_q         <= '0;
                        pend_q        <= 1'b0;
                        frame_min_len <= pol_min;
                        frame_max_len <= pol_max;
                        frame_add_crc <= pol_crc;
                        state_q       <= ST_FETCH;
                    end else if (!ctl_tx_en) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_FETCH: begin
                    if (pend_q) begin
                        if (mem_rsp_valid) begin
                            off_q  <= off_q + LEN_W'(4);
                            pend_q <= 1'b0;
                        end
                    end else if (off_q < len_q) begin
                        if (mem_req_ready) pend_q <= 1'b1;
                    end else begin
                        ptr_q      <= '0;
                        sent_all_q <= 1'b0;
                        state_q    <= ST_TRANSMIT;
                    end
                end
                ST_TRANSMIT: begin
                    if (tx_valid && tx_ready) begin
                        ptr_q <= ptr_q + LEN_W'(1);
                        if (tx_last) sent_all_q <= 1'b1;
                    end
                    if (line_done) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        bd_raddr      = idx;
        bd_waddr      = idx;
        buf_we        = (state_q == ST_FETCH) && pend_q && mem_rsp_valid;
        mem_req_valid = (state_q == ST_FETCH) && !pend_q && (off_q < len_q);
        mem_req_addr  = baddr_q + ADDR_W'(off_q);
        tx_valid      = (state_q == ST_TRANSMIT) && !sent_all_q;
        tx_data       = buf_byte;
        tx_last       = tx_valid && (ptr_q == len_q - LEN_W'(1));
        finish        = (state_q == ST_TRANSMIT) && line_done;
        bd_we         = finish;
        bd_wdata      = desc_q;
        bd_wdata[B_RDY] = 1'b0;
        int_done_set  = finish && !line_err;
        int_err_set   = finish && line_err;
        irq           = desc_q[B_IRQ] &&
                        ((int_done_set && mask_done) || (int_err_set && mask_err));
    end

    AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_BD && $past(state_q) == ST_IDLE) |-> $past(ctl_tx_en)); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_req_valid); // R4
    AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> pend_q); // R4
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid); // R5
    AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_BD && bd_rdata0[B_RDY]) |->
        (bd_rdata0[31:16] != 16'd0 && 32'(bd_rdata0[31:16]) <= BUF_BYTES)); // R3
    AST_INT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_done_set, int_err_set})); // R10
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R13
endmodule

// File: tb/txbd_engine_tb_top.sv
module txbd_engine_tb_top;
    localparam int unsigned NUM_BD    = 8;
    localparam int unsigned BUF_BYTES = 64;
    localparam int unsigned LEN_W     = 16;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned IDX_W     = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              ctl_tx_en = 1'b0, ctl_pad = 1'b0, ctl_huge = 1'b0, ctl_crc_en = 1'b0;
    logic [LEN_W-1:0]  ctl_min_len = 16'd60, ctl_max_len = 16'd1536;
    logic              mask_done = 1'b0, mask_err = 1'b0;
    logic [IDX_W-1:0]  bd_raddr, bd_waddr;
    logic [31:0]       bd_rdata0, bd_rdata1, bd_wdata;
    logic              bd_we;
    logic              mem_req_valid, mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic              tx_valid, tx_last, tx_ready = 1'b0;
    logic [7:0]        tx_data;
    logic              line_done = 1'b0, line_err = 1'b0;
    logic [LEN_W-1:0]  frame_min_len, frame_max_len;
    logic              frame_add_crc, int_done_set, int_err_set, irq;

    logic [31:0] ram [2*NUM_BD];
    assign bd_rdata0 = ram[bd_raddr];
    assign bd_rdata1 = ram[{bd_raddr[IDX_W-1:1], 1'b1}];

    txbd_engine #(.NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_tx_en(ctl_tx_en), .ctl_pad(ctl_pad), .ctl_huge(ctl_huge),
        .ctl_crc_en(ctl_crc_en), .ctl_min_len(ctl_min_len), .ctl_max_len(ctl_max_len),
        .mask_done(mask_done), .mask_err(mask_err), .bd_raddr(bd_raddr), .bd_rdata0(bd_rdata0),
        .bd_rdata1(bd_rdata1), .bd_we(bd_we), .bd_waddr(bd_waddr), .bd_wdata(bd_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .line_done(line_done),
        .line_err(line_err), .frame_min_len(frame_min_len), .frame_max_len(frame_max_len),
        .frame_add_crc(frame_add_crc), .int_done_set(int_done_set), .int_err_set(int_err_set),
        .irq(irq)
    );

    int unsigned n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return (a * 32'h0100_0193) ^ 32'hA5A5_5A5A;
    endfunction

    // Per-frame expectations shared with the environment process
    logic [31:0] exp_addr = '0;
    int          exp_len = 0;
    int          req_cnt = 0, rx_cnt = 0;
    bit          frame_err = 1'b0, frame_done = 1'b0, any_req = 1'b0;
    logic [31:0] wb_data = '0;
    logic [IDX_W-1:0] wb_addr = '0;
    bit          s_txb = 1'b0, s_txe = 1'b0, s_irq = 1'b0;

    function automatic logic [7:0] exp_byte(input int i);
        logic [31:0] w;
        w = memfn(exp_addr + 32'(i & ~3));
        return w[8*(3-(i%4)) +: 8];
    endfunction

    // Environment: memory responder and line sink
    bit          nxt_rdy = 1'b0, nxt_rsp_v = 1'b0, nxt_txr = 1'b0, nxt_done = 1'b0;
    logic [31:0] nxt_rsp_d = '0, rsp_addr = '0;
    int          rsp_cd = 0, done_cd = 0;

    always @(negedge clk) begin
        mem_req_ready = nxt_rdy;
        mem_rsp_valid = nxt_rsp_v;
        mem_rsp_data  = nxt_rsp_d;
        tx_ready      = nxt_txr;
        line_done     = nxt_done;
        line_err      = frame_err;
        #5;
        if (rst_n) begin
            nxt_rsp_v = 1'b0;
            if (rsp_cd > 0) begin
                rsp_cd--;
                if (rsp_cd == 0) begin
                    nxt_rsp_v = 1'b1;
                    nxt_rsp_d = memfn(rsp_addr);
                end
            end
            if (mem_req_valid) any_req = 1'b1;
            if (mem_req_valid && mem_req_ready) begin
                chk(mem_req_addr == exp_addr + 32'(4*req_cnt), "R4 R3 read address",
                    mem_req_addr, exp_addr + 32'(4*req_cnt));
                req_cnt++;
                rsp_addr = mem_req_addr;
                rsp_cd   = 1 + int'($urandom % 3);
            end
            nxt_rdy = ($urandom % 4) != 0;

            if (tx_valid && tx_ready) begin
                chk(tx_data == exp_byte(rx_cnt), "R5 R13 byte", {24'd0, tx_data}, {24'd0, exp_byte(rx_cnt)});
                chk(tx_last == (rx_cnt == exp_len - 1), "R5 last flag", {31'd0, tx_last},
                    {31'd0, rx_cnt == exp_len - 1});
                rx_cnt++;
                if (tx_last) done_cd = 1 + int'($urandom % 3);
            end
            nxt_done = 1'b0;
            if (done_cd > 0) begin
                done_cd--;
                if (done_cd == 0) nxt_done = 1'b1;
            end
            nxt_txr = ($urandom % 3) != 0;

            if (bd_we) begin
                wb_addr = bd_waddr;
                wb_data = bd_wdata;
                ram[bd_waddr] = bd_wdata;
                s_txb = int_done_set;
                s_txe = int_err_set;
                s_irq = irq;
                frame_done = 1'b1;
            end
        end
    end

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary_and_end();
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #6;
    endtask

    int exp_idx = 0;

    task automatic run_frame(input int len, input bit f_irq, input bit f_wrap, input bit f_pad,
                             input bit f_crc, input bit f_last, input bit err, input logic [31:0] addr);
        logic [31:0] word0, exp_wb;
        logic [15:0] e_min, e_max;
        bit          e_crc, e_irq;
        int          slot, nxt, guard;
        slot = exp_idx;
        exp_addr   = addr;
        exp_len    = len;
        req_cnt    = 0;
        rx_cnt     = 0;
        frame_err  = err;
        frame_done = 1'b0;
        word0 = {16'(len), 1'b1, f_irq, f_wrap, f_pad, f_crc, f_last, 10'($urandom)};
        exp_wb = word0 & ~32'h0000_83FE;
        e_min = (f_pad || ctl_pad) ? ctl_min_len : 16'(len);
        e_max = ctl_huge ? 16'(len) : ctl_max_len;
        e_crc = ctl_crc_en || (f_crc && f_last);
        e_irq = f_irq && (err ? mask_err : mask_done);
        ram[slot+1] = addr;
        ram[slot]   = word0;
        guard = 0;
        while (!frame_done && guard < 3000) begin
            wait_cyc(1);
            guard++;
        end
        chk(frame_done, "R9 write-back seen", {31'd0, frame_done}, 32'd1);
        chk(rx_cnt == len, "R5 byte count", 32'(rx_cnt), 32'(len));
        chk(req_cnt == (len + 3) / 4, "R4 read count", 32'(req_cnt), 32'((len + 3) / 4));
        chk(32'(wb_addr) == 32'(slot), "R9 write-back slot", 32'(wb_addr), 32'(slot));
        chk(wb_data == exp_wb, "R9 write-back word", wb_data, exp_wb);
        chk(s_txb == !err, "R10 done source", {31'd0, s_txb}, {31'd0, !err});
        chk(s_txe == err, "R10 error source", {31'd0, s_txe}, {31'd0, err});
        chk(s_irq == e_irq, "R11 irq", {31'd0, s_irq}, {31'd0, e_irq});
        chk(frame_min_len == e_min, "R6 min length", 32'(frame_min_len), 32'(e_min));
        chk(frame_max_len == e_max, "R7 max length", 32'(frame_max_len), 32'(e_max));
        chk(frame_add_crc == e_crc, "R8 crc decision", {31'd0, frame_add_crc}, {31'd0, e_crc});
        nxt = (f_wrap || slot == 2*NUM_BD - 2) ? 0 : slot + 2;
        wait_cyc(1);
        chk(32'(bd_raddr) == 32'(nxt), "R12 next index", 32'(bd_raddr), 32'(nxt));
        exp_idx = nxt;
    endtask

    int seed_dummy;

    initial begin
        seed_dummy = int'($urandom(32'd20240611));
        for (int i = 0; i < 2*NUM_BD; i++) ram[i] = '0;
        wait_cyc(3);
        chk(bd_raddr == '0, "R1 reset index", 32'(bd_raddr), 32'd0);
        chk({mem_req_valid, tx_valid, bd_we} == 3'b000, "R1 reset valids",
            {29'd0, mem_req_valid, tx_valid, bd_we}, 32'd0);
        chk({int_done_set, int_err_set, irq} == 3'b000, "R1 reset interrupts",
            {29'd0, int_done_set, int_err_set, irq}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(bd_raddr == '0 && !mem_req_valid, "R1 idle after reset", 32'(bd_raddr), 32'd0);

        // R2: disabled engine ignores a ready descriptor
        ram[1] = 32'h0000_1000;
        ram[0] = {16'd8, 1'b1, 15'd0};
        any_req = 1'b0;
        wait_cyc(20);
        chk(!any_req, "R2 disabled no fetch", {31'd0, any_req}, 32'd0);
        // R2: enabled but not ready spins
        ram[0] = '0;
        ctl_tx_en = 1'b1;
        wait_cyc(20);
        chk(!any_req && bd_raddr == '0, "R2 spin while not ready", {31'd0, any_req}, 32'd0);
        // R2: enable dropped before ready returns to idle
        ctl_tx_en = 1'b0;
        wait_cyc(5);
        ram[0] = {16'd8, 1'b1, 15'd0};
        wait_cyc(20);
        chk(!any_req, "R2 back to idle", {31'd0, any_req}, 32'd0);
        ram[0] = '0;
        ctl_tx_en = 1'b1;

        // Directed corner lengths
        mask_done = 1'b1; mask_err = 1'b1;
        run_frame(1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_2000);
        run_frame(4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_3004);
        run_frame(5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_4003);
        ctl_huge = 1'b1; ctl_pad = 1'b1; ctl_crc_en = 1'b1;
        run_frame(BUF_BYTES, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0001_0000);
        ctl_huge = 1'b0; ctl_pad = 1'b0; ctl_crc_en = 1'b0;
        mask_done = 1'b0;
        run_frame(3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_5000);
        mask_done = 1'b1; mask_err = 1'b0;
        run_frame(7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_6000);

        // Random frames
        for (int n = 0; n < 30; n++) begin
            ctl_pad     = 1'($urandom);
            ctl_huge    = 1'($urandom);
            ctl_crc_en  = ($urandom % 4) == 0;
            ctl_min_len = 16'(40 + $urandom % 40);
            ctl_max_len = 16'(100 + $urandom % 2000);
            mask_done   = 1'($urandom);
            mask_err    = 1'($urandom);
            run_frame(1 + int'($urandom % BUF_BYTES), 1'($urandom), ($urandom % 5) == 0,
                      1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                      $urandom & 32'h00FF_FFFF);
        end
        summary_and_end();
    end
endmodule